// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the multi-cycle control unit of a small accumulator machine. It runs each instruction as a series of subcycles. Fetch reads the next instruction word. Indirect, when the instruction asks for it, reads a pointer that becomes the operand address. Execute performs a load, a store, an add or a jump. Interrupt entry runs only between instructions. Data moves through four internal registers: a program counter, a memory address register, a memory buffer register and an instruction register. An accumulator holds the working value.

The block drives a single-port synchronous memory. Every access holds the memory address register on the address port for one request cycle. Write data always comes from the memory buffer register. Read data comes back on the cycle after the request.

An external request line and an enable bit control interrupts. When both are high at the end of an execute subcycle, the block writes the address of the next instruction to a fixed save location and then fetches from a fixed handler address. The current instruction word and a two-bit subcycle code are brought out for observation.

Top module: `icyc_seq`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the address and buffer registers, the instruction register and the accumulator, and leaves the block in fetch. While reset is held, `ir_out`, `mem_addr` and `mem_wdata` read 0 and neither request is high. The first access after reset is a fetch read of address 0.
- R2: Fetch presents the program counter on `mem_addr` with `mem_rd` high for one cycle. The returned word lands in `ir_out`, and the program counter advances by one, so that instructions that do not jump are fetched from consecutive addresses.
- R3: An instruction word has bit 15 as the indirect flag, bits 14:12 as the opcode and bits 11:0 as the address field. When bit 15 is set, one indirect read of the address field follows fetch, and bits 11:0 of the word it returns become the operand address.
- R4: Opcode 0 (load) reads the operand address and places the word in the accumulator.
- R5: Opcode 1 (store) writes the accumulator to the operand address.
- R6: Opcode 2 (add) reads the operand address and adds the word to the accumulator, modulo 2^16.
- R7: Opcode 3 (jump) makes no memory access in execute, and the next fetch reads the operand address.
- R8: Opcodes 4 to 7 make no memory access and leave the accumulator unchanged; the next fetch is at the following address.
- R9: Interrupt entry writes the address of the next instruction, zero-extended, to address 0 and then fetches from address 1.
- R10: While `irq_en` is low, `irq` has no effect on the access sequence.
- R11: An interrupt is taken only when an execute subcycle ends. A request that rises during an instruction lets that instruction's accesses complete first.
- R12: Each access holds its request for exactly one cycle, and `mem_rd` and `mem_wr` are never high together. `phase_out` reads 0 in fetch, 1 in indirect, 2 in execute and 3 in interrupt entry. `ir_out` changes only at the end of a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_wdata | output | 16 | Memory write data (memory buffer register) |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read request |
| mem_rd | output | 1 | Read request, one cycle per access |
| mem_wr | output | 1 | Write request, one cycle per access |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_en | input | 1 | Interrupt enable |
| ir_out | output | 16 | Instruction register |
| phase_out | output | 2 | Subcycle code: 0 fetch, 1 indirect, 2 execute, 3 interrupt |

## Verification
The assertions assume that the memory answers every read on the very next cycle and keeps that word on `mem_rdata` until the buffer register captures it. They also assume that the interrupt request is a level held steady until entry is seen. The bench memory model returns data on the clock edge that follows each read request, so the first assumption holds by construction. The bench raises `irq_en` only on an instruction fetch, and it drops `irq` only once the save write has appeared on the memory port. This way an interrupt enters exactly once, at a point known in advance.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int OPW = 3;
    localparam int IND_BIT = DW - 1;
    localparam int OP_LSB  = IND_BIT - OPW;
    localparam int EXT_W   = DW - AW;

    localparam logic [AW-1:0] SAVE_ADDR    = AW'(0);
    localparam logic [AW-1:0] HANDLER_ADDR = AW'(1);

    localparam logic [OPW-1:0] OP_LOAD  = OPW'(0);
    localparam logic [OPW-1:0] OP_STORE = OPW'(1);
    localparam logic [OPW-1:0] OP_ADD   = OPW'(2);
    localparam logic [OPW-1:0] OP_JUMP  = OPW'(3);

    typedef enum logic [1:0] {
        PH_FETCH    = 2'd0,
        PH_INDIRECT = 2'd1,
        PH_EXECUTE  = 2'd2,
        PH_INTR     = 2'd3
    } phase_e;

    typedef enum logic [3:0] {
        S_F_MAR, S_F_REQ, S_F_MBR, S_F_IR,
        S_I_MAR, S_I_REQ, S_I_MBR,
        S_E_MAR, S_E_REQ, S_E_MBR, S_E_ACC,
        S_N_MBR, S_N_WR
    } step_e;

    typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_EA, PC_HANDLER} pc_sel_e;
    typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_EA, MAR_SAVE} mar_sel_e;
    typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_PC, MBR_ACC} mbr_sel_e;
    typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_ADD} acc_sel_e;

    typedef struct packed {
        pc_sel_e  pc;
        mar_sel_e mar;
        mbr_sel_e mbr;
        acc_sel_e acc;
        logic     ir_ld;
        logic     rd;
        logic     wr;
    } ctl_t;

    function automatic phase_e phase_of(input step_e s);
        case (s)
            S_F_MAR, S_F_REQ, S_F_MBR, S_F_IR: return PH_FETCH;
            S_I_MAR, S_I_REQ, S_I_MBR:         return PH_INDIRECT;
            S_N_MBR, S_N_WR:                   return PH_INTR;
            default:                           return PH_EXECUTE;
        endcase
    endfunction

    function automatic logic [OPW-1:0] op_field(input logic [DW-1:0] w);
        return w[IND_BIT-1:OP_LSB];
    endfunction

endpackage

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
    import icyc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] ir_op,
    input  logic           mbr_ind,
    input  logic           irq,
    input  logic           irq_en,
    output ctl_t           ctl,
    output phase_e         phase
);

    step_e step, step_nx;
    logic  take_irq;

    assign take_irq = irq && irq_en;
    assign phase    = phase_of(step);

    always_ff @(posedge clk) begin
        if (rst) step <= S_F_MAR;
        else     step <= step_nx;
    end

    always_comb begin
        ctl     = '0;
        step_nx = S_F_MAR;
        case (step)
            S_F_MAR: begin ctl.mar = MAR_PC; step_nx = S_F_REQ; end
            S_F_REQ: begin ctl.rd = 1'b1; ctl.pc = PC_INC; step_nx = S_F_MBR; end
            S_F_MBR: begin ctl.mbr = MBR_MEM; step_nx = S_F_IR; end
            S_F_IR: begin
                ctl.ir_ld = 1'b1;
                step_nx   = mbr_ind ? S_I_MAR : S_E_MAR;
            end
            S_I_MAR: begin ctl.mar = MAR_EA; step_nx = S_I_REQ; end
            S_I_REQ: begin ctl.rd = 1'b1; step_nx = S_I_MBR; end
            S_I_MBR: begin ctl.mbr = MBR_MEM; step_nx = S_E_MAR; end
            S_E_MAR: begin
                case (ir_op)
                    OP_LOAD, OP_ADD: begin ctl.mar = MAR_EA; step_nx = S_E_REQ; end
                    OP_STORE: begin
                        ctl.mar = MAR_EA;
                        ctl.mbr = MBR_ACC;
                        step_nx = S_E_REQ;
                    end
                    OP_JUMP: begin
                        ctl.pc  = PC_EA;
                        step_nx = take_irq ? S_N_MBR : S_F_MAR;
                    end
                    default: step_nx = take_irq ? S_N_MBR : S_F_MAR;
                endcase
            end
            S_E_REQ: begin
                if (ir_op == OP_STORE) begin
                    ctl.wr  = 1'b1;
                    step_nx = take_irq ? S_N_MBR : S_F_MAR;
                end else begin
                    ctl.rd  = 1'b1;
                    step_nx = S_E_MBR;
                end
            end
            S_E_MBR: begin ctl.mbr = MBR_MEM; step_nx = S_E_ACC; end
            S_E_ACC: begin
                ctl.acc = (ir_op == OP_ADD) ? ACC_ADD : ACC_LOAD;
                step_nx = take_irq ? S_N_MBR : S_F_MAR;
            end
            S_N_MBR: begin ctl.mbr = MBR_PC; ctl.mar = MAR_SAVE; step_nx = S_N_WR; end
            S_N_WR:  begin ctl.wr = 1'b1; ctl.pc = PC_HANDLER; step_nx = S_F_MAR; end
            default: step_nx = S_F_MAR;
        endcase
    end

    // R12: a request is never held into a second cycle
    a_r12_one_cycle_req: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd || ctl.wr) |=> !(ctl.rd || ctl.wr));

    // R12: read and write never together
    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(ctl.rd && ctl.wr));

    // R10: interrupt entry requires both the request and the enable
    a_r10_entry_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (step == S_N_MBR) |-> $past(irq && irq_en));

    // R11: interrupt entry follows only the last step of an execute subcycle
    a_r11_entry_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (step == S_N_MBR) |-> ($past(step) == S_E_MAR || $past(step) == S_E_REQ
                               || $past(step) == S_E_ACC));

endmodule

// File: rtl/icyc_alu.sv
module icyc_alu
    import icyc_pkg::*;
(
    input  acc_sel_e       sel,
    input  logic [DW-1:0]  acc,
    input  logic [DW-1:0]  operand,
    output logic [DW-1:0]  acc_nx
);

    always_comb begin
        case (sel)
            ACC_LOAD: acc_nx = operand;
            ACC_ADD:  acc_nx = acc + operand;
            default:  acc_nx = acc;
        endcase
    end

endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
    import icyc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  ctl_t           ctl,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [DW-1:0]  acc_nx,
    output logic [AW-1:0]  pc,
    output logic [AW-1:0]  mar,
    output logic [DW-1:0]  mbr,
    output logic [DW-1:0]  ir,
    output logic [DW-1:0]  acc
);

    logic [AW-1:0] ea;
    assign ea = mbr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            acc <= '0;
        end else begin
            case (ctl.pc)
                PC_INC:     pc <= pc + AW'(1);
                PC_EA:      pc <= ea;
                PC_HANDLER: pc <= HANDLER_ADDR;
                default:    pc <= pc;
            endcase
            case (ctl.mar)
                MAR_PC:   mar <= pc;
                MAR_EA:   mar <= ea;
                MAR_SAVE: mar <= SAVE_ADDR;
                default:  mar <= mar;
            endcase
            case (ctl.mbr)
                MBR_MEM: mbr <= mem_rdata;
                MBR_PC:  mbr <= {{EXT_W{1'b0}}, pc};
                MBR_ACC: mbr <= acc;
                default: mbr <= mbr;
            endcase
            if (ctl.ir_ld) ir <= mbr;
            acc <= acc_nx;
        end
    end

    // R7: a jump redirects the counter to the operand address
    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc == PC_EA) |=> (pc == $past(ea)));

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
    import icyc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [11:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic          irq,
    input  logic          irq_en,
    output logic [15:0]   ir_out,
    output logic [1:0]    phase_out
);

    ctl_t          ctl;
    phase_e        phase;
    logic [AW-1:0] pc, mar;
    logic [DW-1:0] mbr, ir, acc, acc_nx;

    icyc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ir_op   (op_field(ir)),
        .mbr_ind (mbr[IND_BIT]),
        .irq     (irq),
        .irq_en  (irq_en),
        .ctl     (ctl),
        .phase   (phase)
    );

    icyc_alu u_alu (
        .sel     (ctl.acc),
        .acc     (acc),
        .operand (mbr),
        .acc_nx  (acc_nx)
    );

    icyc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .acc_nx    (acc_nx),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .acc       (acc)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign ir_out    = ir;
    assign phase_out = phase;

    // R2: a fetch read addresses the not yet advanced program counter
    a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && phase == PH_FETCH) |-> (mem_addr == pc));

    // R2: the program counter advances by one across a fetch read
    a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && phase == PH_FETCH) |=> (pc == $past(pc) + AW'(1)));

    // R9: the save write goes to the save location and carries the counter
    a_r9_save_write: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && phase == PH_INTR) |-> (mem_addr == SAVE_ADDR && mem_wdata == {{EXT_W{1'b0}}, pc}));

    // R9: after the save write the counter points at the handler
    a_r9_handler_next: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && phase == PH_INTR) |=> (pc == HANDLER_ADDR && phase == PH_FETCH));

    // R12: the instruction register moves only out of a fetch cycle
    a_r12_ir_stable: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_FETCH) |=> $stable(ir_out));

endmodule

// File: tb/icyc_seq_bench.sv
module icyc_seq_bench;

    typedef struct packed {
        logic [11:0] addr;
        logic [15:0] data;
        logic        wr;
        logic [1:0]  ph;
        logic [15:0] ir;
        logic        chk_ir;
        logic [7:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_wr;
    logic        irq = 1'b1;
    logic        irq_en = 1'b0;
    logic [15:0] ir_out;
    logic [1:0]  phase_out;

    logic [15:0] mem [256];
    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    icyc_seq u_icyc_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .irq       (irq),
        .irq_en    (irq_en),
        .ir_out    (ir_out),
        .phase_out (phase_out)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [15:0] ins(input logic ind, input logic [2:0] op, input logic [11:0] a);
        return {ind, op, a};
    endfunction

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic exp_rd(input logic [11:0] a, input logic [1:0] ph, input logic [15:0] irv,
                          input logic chk, input int req);
        q.push_back('{addr: a, data: 16'h0, wr: 1'b0, ph: ph, ir: irv, chk_ir: chk, req: 8'(req)});
    endtask

    task automatic exp_wr(input logic [11:0] a, input logic [15:0] d, input logic [1:0] ph,
                          input logic [15:0] irv, input int req);
        q.push_back('{addr: a, data: d, wr: 1'b1, ph: ph, ir: irv, chk_ir: 1'b1, req: 8'(req)});
    endtask

    // monitor: compare every access against the scoreboard
    always @(negedge clk) begin
        if (!rst && (mem_rd || mem_wr)) begin
            if (mem_rd && mem_addr == 12'h021 && phase_out == 2'd0) irq_en = 1'b1;
            if (mem_wr && phase_out == 2'd3) irq = 1'b0;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                check(int'(e.req), {31'd0, mem_wr}, {31'd0, e.wr}, "access kind");
                check(int'(e.req), {20'd0, mem_addr}, {20'd0, e.addr}, "address");
                check(12, {30'd0, phase_out}, {30'd0, e.ph}, "subcycle code");
                check(12, {31'd0, mem_rd && mem_wr}, 32'd0, "rd and wr together");
                if (e.wr) check(int'(e.req), {16'd0, mem_wdata}, {16'd0, e.data}, "write data");
                if (e.chk_ir) check(12, {16'd0, ir_out}, {16'd0, e.ir}, "instruction register");
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        mem[8'h00] = ins(0, 3, 12'h010);
        mem[8'h01] = ins(1, 3, 12'h000);
        mem[8'h10] = ins(0, 0, 12'h080);
        mem[8'h11] = ins(0, 2, 12'h081);
        mem[8'h12] = ins(0, 1, 12'h082);
        mem[8'h13] = ins(1, 0, 12'h083);
        mem[8'h14] = ins(0, 5, 12'h085);
        mem[8'h15] = ins(0, 1, 12'h086);
        mem[8'h16] = ins(0, 3, 12'h020);
        mem[8'h17] = ins(0, 1, 12'h087);
        mem[8'h20] = ins(1, 1, 12'h088);
        mem[8'h21] = ins(0, 0, 12'h08A);
        mem[8'h22] = ins(0, 3, 12'h022);
        mem[8'h80] = 16'h1234;
        mem[8'h81] = 16'hF000;
        mem[8'h83] = 16'hF084;
        mem[8'h84] = 16'h5555;
        mem[8'h88] = 16'h0089;
        mem[8'h8A] = 16'h0007;

        // R1: first access is a fetch of address 0; R7 jump, no execute access
        exp_rd(12'h000, 0, 0, 0, 1);
        exp_rd(12'h010, 0, 0, 0, 7);
        exp_rd(12'h080, 2, ins(0, 0, 12'h080), 1, 4);          // R4 load
        exp_rd(12'h011, 0, 0, 0, 2);                           // R2 consecutive
        exp_rd(12'h081, 2, ins(0, 2, 12'h081), 1, 6);          // R6 add
        exp_rd(12'h012, 0, 0, 0, 2);
        exp_wr(12'h082, 16'h0234, 2, ins(0, 1, 12'h082), 6);   // R5 store of wrapped sum
        exp_rd(12'h013, 0, 0, 0, 2);
        exp_rd(12'h083, 1, ins(1, 0, 12'h083), 1, 3);          // R3 indirect read
        exp_rd(12'h084, 2, ins(1, 0, 12'h083), 1, 3);          // R3 low 12 bits only
        exp_rd(12'h014, 0, 0, 0, 2);
        exp_rd(12'h015, 0, 0, 0, 8);                           // R8 no access for op 5
        exp_wr(12'h086, 16'h5555, 2, ins(0, 1, 12'h086), 8);   // R8 acc unchanged
        exp_rd(12'h016, 0, 0, 0, 2);
        exp_rd(12'h020, 0, 0, 0, 7);                           // R7 jump skips 0x017
        exp_rd(12'h088, 1, ins(1, 1, 12'h088), 1, 3);
        exp_wr(12'h089, 16'h5555, 2, ins(1, 1, 12'h088), 5);   // R5 indirect store
        exp_rd(12'h021, 0, 0, 0, 10);                          // R10 irq held, no entry so far
        exp_rd(12'h08A, 2, ins(0, 0, 12'h08A), 1, 11);         // R11 load completes first
        exp_wr(12'h000, 16'h0022, 3, ins(0, 0, 12'h08A), 9);   // R9 save next address
        exp_rd(12'h001, 0, 0, 0, 9);                           // R9 handler fetch
        exp_rd(12'h000, 1, ins(1, 3, 12'h000), 1, 9);          // R9 handler reads saved value
        exp_rd(12'h022, 0, 0, 0, 9);
        exp_rd(12'h022, 0, 0, 0, 7);
        exp_rd(12'h022, 0, 0, 0, 7);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        check(1, {16'd0, ir_out}, 32'd0, "ir after reset");
        check(1, {30'd0, phase_out}, 32'd0, "subcycle after reset");
        check(1, {20'd0, mem_addr}, 32'd0, "address after reset");
        check(1, {16'd0, mem_wdata}, 32'd0, "write data after reset");
        check(1, {30'd0, mem_rd, mem_wr}, 32'd0, "requests during reset");
        rst = 1'b0;

        begin
            int cyc = 0;
            while (q.size() != 0 && cyc < 20000) begin
                @(posedge clk);
                cyc++;
            end
        end
        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog: actual %0d pending expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule